// File: doc/BRIEF.md
# Peripheral FIFO Burst DMA Channel

This block is one DMA channel that moves a buffer between a peripheral FIFO and system memory in fixed-size units (8, 16 or 32 bytes, selected in the control word). Software sets it up through a small word-addressed register bus. It loads the memory and device-side addresses, the number of units, a byte-valid mask for the final unit, and then sets the channel enable. The channel then issues one memory request per unit on a request/acknowledge handshake. The request carries the memory-side address, a direction flag and per-byte strobes. After each acknowledged unit, the memory-side address advances by one unit and the unit count drops by one. Software can read the address back to work out how many bytes remain.

The transfer ends when the count reaches zero. Two other events are reported in the same status word. The first is a stop request from the peripheral, which halts the channel. The second is a zero-length packet from the peripheral, when detection of it is enabled; software answers it by writing a force-end bit, which closes the transfer early. The interrupt output combines all three events under an interrupt-enable bit. A chip-level enable and an address-error flag gate every new request. Direction is a static input: device-to-memory writes memory at the destination address, and memory-to-device reads memory at the source address.

Top module: `fifo_burst_dma`

## Requirements
- R1: After reset every register reads zero, `mem_req` is low and `irq` is low.
- R2: Register byte offsets are source address 0x00, destination address 0x04, unit count 0x08 (24 bits, upper bits read zero), control/status 0x14 and final-unit mask 0x18; written values read back.
- R3: While enable (control bit 0) is 1, end flag (bit 1), stop flag (bit 2) and force-end (bit 24) are 0, the run condition holds and the count is non-zero, the channel raises `mem_req`. It holds the request until `mem_ack` and makes exactly one request per unit.
- R4: Each acknowledged unit adds the unit size to the memory-side address and subtracts one from the count. With `dev_to_mem`=1 the destination address is used and `mem_we`=1. With `dev_to_mem`=0 the source address is used and `mem_we`=0. The other address register is left unchanged.
- R5: Control bits 7:6 select the unit size: 00 = 8 bytes, 01 = 16 bytes, 10 or 11 = 32 bytes. No strobe bit at or above the unit size is ever set.
- R6: On a non-final unit, strobe bit i (byte i) is set for every byte of the unit. On the final unit (count = 1), byte i is valid only when mask bit 31−i is set.
- R7: The end flag (bit 1) sets when the last unit is acknowledged, and no request follows while it is set.
- R8: `irq` is high exactly when interrupt-enable (bit 5) is 1 and at least one of end, stop or null flag (bit 12) is set.
- R9: The end, stop and null flags clear when written with 0; writing 1 to a clear flag leaves it clear.
- R10: A pulse on `stop_req` while the channel is busy (enable 1, end flag 0) sets the stop flag. No new request is issued afterwards; a request already in flight completes.
- R11: A pulse on `null_pkt` while busy sets the null flag only when null-detect enable (bit 16) is 1; otherwise it is ignored.
- R12: Writing force-end (bit 24) = 1 while busy sets the end flag once no request is in flight, leaving the count as it was. Force-end then reads back 0.
- R13: No new request starts while `glob_en` is 0 or `addr_err` is 1; the transfer resumes when both return to their run values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| glob_en | input | 1 | Chip-level DMA enable |
| addr_err | input | 1 | Chip-level address-error flag |
| dev_to_mem | input | 1 | Static direction: 1 = device to memory |
| stop_req | input | 1 | Stop request from the peripheral |
| null_pkt | input | 1 | Zero-length packet seen by the peripheral |
| mem_req | output | 1 | Memory unit request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory-side address of the unit |
| mem_strb | output | 32 | Byte strobes, bit i = byte i of the unit |
| mem_ack | input | 1 | Memory acknowledge; completes the unit |
| irq | output | 1 | Channel interrupt |

## Verification
The assertions assume that software does not rewrite the registers in the cycle they examine. Each property excludes cycles with `reg_we` high, and the bench writes registers only while the channel is idle or stalled by the run condition. They also assume that `dev_to_mem` changes only between transfers, and that `mem_ack` is given only while `mem_req` is high. The bench's acknowledge model sets `mem_ack` from the sampled request, after a programmable wait of zero to three cycles. It changes direction only after a transfer has ended.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;

  localparam logic [4:0] OFS_SRC = 5'h00;
  localparam logic [4:0] OFS_DST = 5'h04;
  localparam logic [4:0] OFS_CNT = 5'h08;
  localparam logic [4:0] OFS_CTL = 5'h14;
  localparam logic [4:0] OFS_MSK = 5'h18;

  localparam int BIT_EN    = 0;
  localparam int BIT_END   = 1;
  localparam int BIT_STOP  = 2;
  localparam int BIT_IE    = 5;
  localparam int BIT_SZ    = 6;
  localparam int BIT_NULF  = 12;
  localparam int BIT_NULEN = 16;
  localparam int BIT_FORCE = 24;

  typedef enum logic [1:0] {
    SZ_8   = 2'b00,
    SZ_16  = 2'b01,
    SZ_32  = 2'b10,
    SZ_RSV = 2'b11
  } unit_size_e;

  typedef struct packed {
    logic       force_end;
    logic       null_en;
    logic       null_flag;
    unit_size_e usize;
    logic       ie;
    logic       stop_flag;
    logic       end_flag;
    logic       en;
  } ctl_t;

  // Bytes moved per unit for a size code; the reserved code behaves as 32.
  function automatic int unit_bytes(input unit_size_e s);
    case (s)
      SZ_8:    return 8;
      SZ_16:   return 16;
      default: return 32;
    endcase
  endfunction

  // Places the control fields at their bit positions in the status word.
  function automatic logic [31:0] ctl_word(input ctl_t c);
    logic [31:0] w;
    w = '0;
    w[BIT_EN]         = c.en;
    w[BIT_END]        = c.end_flag;
    w[BIT_STOP]       = c.stop_flag;
    w[BIT_IE]         = c.ie;
    w[BIT_SZ+1:BIT_SZ] = c.usize;
    w[BIT_NULF]       = c.null_flag;
    w[BIT_NULEN]      = c.null_en;
    w[BIT_FORCE]      = c.force_end;
    return w;
  endfunction

endpackage

// File: rtl/fbdma_strobe.sv
module fbdma_strobe #(
  parameter int UNIT_BYTES = 32,
  parameter int SW         = $clog2(UNIT_BYTES) + 1
) (
  input  logic [UNIT_BYTES-1:0] last_mask,
  input  logic                  last_unit,
  input  logic [SW-1:0]         step,
  output logic [UNIT_BYTES-1:0] strb
);

  // Byte i lies inside the unit when i < step; on the last unit its valid
  // bit is taken from the mask, packed from the top bit downwards.
  for (genvar i = 0; i < UNIT_BYTES; i++) begin : g_byte
    assign strb[i] = (SW'(i) < step) && (!last_unit || last_mask[UNIT_BYTES-1-i]);
  end

endmodule

// File: rtl/fbdma_seq.sv
module fbdma_seq #(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_src,
  input  logic          wr_dst,
  input  logic          wr_cnt,
  input  logic [AW-1:0] wr_addr_val,
  input  logic [CW-1:0] wr_cnt_val,
  input  logic          dev_to_mem,
  input  logic          launch_ok,
  input  logic [SW-1:0] step,
  input  logic          mem_ack,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic          req_q,
  output logic          unit_done,
  output logic          last_unit,
  output logic          cnt_zero
);

  assign unit_done = req_q && mem_ack;
  assign last_unit = (cnt_q == CW'(1));
  assign cnt_zero  = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      if (wr_src)                        src_q <= wr_addr_val;
      else if (unit_done && !dev_to_mem) src_q <= src_q + AW'(step);

      if (wr_dst)                        dst_q <= wr_addr_val;
      else if (unit_done && dev_to_mem)  dst_q <= dst_q + AW'(step);

      if (wr_cnt)                        cnt_q <= wr_cnt_val;
      else if (unit_done)                cnt_q <= cnt_q - CW'(1);

      if (unit_done)                     req_q <= 1'b0;
      else if (launch_ok && !cnt_zero)   req_q <= 1'b1;
    end
  end

endmodule

// File: rtl/fbdma_ctrl.sv
module fbdma_ctrl
  import fbdma_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ctl,
  input  ctl_t  wr_val,
  input  logic  run,
  input  logic  req_busy,
  input  logic  unit_done,
  input  logic  last_unit,
  input  logic  cnt_zero,
  input  logic  stop_req,
  input  logic  null_pkt,
  output ctl_t  ctl_q,
  output logic  launch_ok,
  output logic  irq
);

  logic busy;
  logic end_set, stop_set, null_set;
  ctl_t nxt;

  assign busy     = ctl_q.en && !ctl_q.end_flag;
  assign end_set  = (unit_done && last_unit)
                 || (busy && !req_busy && run && cnt_zero)
                 || (busy && !req_busy && ctl_q.force_end);
  assign stop_set = busy && stop_req;
  assign null_set = busy && ctl_q.null_en && null_pkt;

  assign launch_ok = ctl_q.en && !ctl_q.end_flag && !ctl_q.stop_flag
                  && !ctl_q.force_end && run;
  assign irq = ctl_q.ie && (ctl_q.end_flag || ctl_q.stop_flag || ctl_q.null_flag);

  always_comb begin
    nxt = ctl_q;
    if (wr_ctl) begin
      nxt.en        = wr_val.en;
      nxt.ie        = wr_val.ie;
      nxt.usize     = wr_val.usize;
      nxt.null_en   = wr_val.null_en;
      // status flags: a written 0 clears, a written 1 keeps the old value
      nxt.end_flag  = ctl_q.end_flag  && wr_val.end_flag;
      nxt.stop_flag = ctl_q.stop_flag && wr_val.stop_flag;
      nxt.null_flag = ctl_q.null_flag && wr_val.null_flag;
      nxt.force_end = wr_val.force_end;
    end else begin
      // force-end is consumed as soon as no unit is in flight
      nxt.force_end = ctl_q.force_end && req_busy;
    end
    nxt.end_flag  = nxt.end_flag  || end_set;
    nxt.stop_flag = nxt.stop_flag || stop_set;
    nxt.null_flag = nxt.null_flag || null_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= nxt;
  end

endmodule

// File: rtl/fifo_burst_dma.sv
module fifo_burst_dma
  import fbdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 24,
  parameter int UNIT_BYTES = 32,
  parameter int RAW        = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [RAW-1:0]        reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  glob_en,
  input  logic                  addr_err,
  input  logic                  dev_to_mem,
  input  logic                  stop_req,
  input  logic                  null_pkt,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [UNIT_BYTES-1:0] mem_strb,
  input  logic                  mem_ack,
  output logic                  irq
);

  localparam int SW = $clog2(UNIT_BYTES) + 1;

  // decoded register writes
  logic wr_src, wr_dst, wr_cnt, wr_ctl, wr_msk;
  assign wr_src = reg_we && (reg_addr == OFS_SRC);
  assign wr_dst = reg_we && (reg_addr == OFS_DST);
  assign wr_cnt = reg_we && (reg_addr == OFS_CNT);
  assign wr_ctl = reg_we && (reg_addr == OFS_CTL);
  assign wr_msk = reg_we && (reg_addr == OFS_MSK);

  ctl_t wr_ctl_val;
  always_comb begin
    wr_ctl_val           = '0;
    wr_ctl_val.en        = reg_wdata[BIT_EN];
    wr_ctl_val.end_flag  = reg_wdata[BIT_END];
    wr_ctl_val.stop_flag = reg_wdata[BIT_STOP];
    wr_ctl_val.ie        = reg_wdata[BIT_IE];
    wr_ctl_val.usize     = unit_size_e'(reg_wdata[BIT_SZ+1:BIT_SZ]);
    wr_ctl_val.null_flag = reg_wdata[BIT_NULF];
    wr_ctl_val.null_en   = reg_wdata[BIT_NULEN];
    wr_ctl_val.force_end = reg_wdata[BIT_FORCE];
  end

  // final-unit byte mask
  logic [UNIT_BYTES-1:0] mask_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      mask_q <= '0;
    else if (wr_msk) mask_q <= reg_wdata[UNIT_BYTES-1:0];
  end

  // named internal events, brought out for the checker
  ctl_t           ctl_q;
  logic           run, launch_ok, unit_done, last_unit, cnt_zero;
  logic           te_flag, fte_flag;
  logic [SW-1:0]  step_bytes;
  logic [AW-1:0]  src_q, dst_q;
  logic [CW-1:0]  cnt_q;

  assign run        = glob_en && !addr_err;
  assign step_bytes = SW'(unit_bytes(ctl_q.usize));
  assign te_flag    = ctl_q.end_flag;
  assign fte_flag   = ctl_q.force_end;

  fbdma_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctl    (wr_ctl),
    .wr_val    (wr_ctl_val),
    .run       (run),
    .req_busy  (mem_req),
    .unit_done (unit_done),
    .last_unit (last_unit),
    .cnt_zero  (cnt_zero),
    .stop_req  (stop_req),
    .null_pkt  (null_pkt),
    .ctl_q     (ctl_q),
    .launch_ok (launch_ok),
    .irq       (irq)
  );

  fbdma_seq #(.AW(AW), .CW(CW), .SW(SW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_src      (wr_src),
    .wr_dst      (wr_dst),
    .wr_cnt      (wr_cnt),
    .wr_addr_val (reg_wdata[AW-1:0]),
    .wr_cnt_val  (reg_wdata[CW-1:0]),
    .dev_to_mem  (dev_to_mem),
    .launch_ok   (launch_ok),
    .step        (step_bytes),
    .mem_ack     (mem_ack),
    .src_q       (src_q),
    .dst_q       (dst_q),
    .cnt_q       (cnt_q),
    .req_q       (mem_req),
    .unit_done   (unit_done),
    .last_unit   (last_unit),
    .cnt_zero    (cnt_zero)
  );

  fbdma_strobe #(.UNIT_BYTES(UNIT_BYTES), .SW(SW)) u_strb (
    .last_mask (mask_q),
    .last_unit (last_unit),
    .step      (step_bytes),
    .strb      (mem_strb)
  );

  assign mem_we   = dev_to_mem;
  assign mem_addr = dev_to_mem ? dst_q : src_q;

  always_comb begin
    case (reg_addr)
      OFS_SRC: reg_rdata = 32'(src_q);
      OFS_DST: reg_rdata = 32'(dst_q);
      OFS_CNT: reg_rdata = 32'(cnt_q);
      OFS_CTL: reg_rdata = ctl_word(ctl_q);
      OFS_MSK: reg_rdata = 32'(mask_q);
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/fbdma_checker.sv
module fbdma_checker #(
  parameter int AW         = 32,
  parameter int UNIT_BYTES = 32,
  parameter int SW         = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we,
  input logic                  glob_en,
  input logic                  addr_err,
  input logic                  mem_req,
  input logic                  mem_ack,
  input logic [AW-1:0]         mem_addr,
  input logic [UNIT_BYTES-1:0] mem_strb,
  input logic [SW-1:0]         step_bytes,
  input logic                  te_flag,
  input logic                  fte_flag
);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !reg_we) |=> (mem_req && $stable(mem_addr) && $stable(mem_strb)));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !reg_we) |=> (mem_addr == $past(mem_addr) + AW'($past(step_bytes))));

  assert_strobe_in_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_strb >> step_bytes) == '0));

  assert_end_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    te_flag |-> !$rose(mem_req));

  assert_force_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fte_flag && !mem_req && !reg_we) |=> !fte_flag);

  assert_run_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(glob_en && !addr_err));

endmodule

bind fifo_burst_dma fbdma_checker #(.AW(AW), .UNIT_BYTES(UNIT_BYTES), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .glob_en    (glob_en),
  .addr_err   (addr_err),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .mem_strb   (mem_strb),
  .step_bytes (step_bytes),
  .te_flag    (te_flag),
  .fte_flag   (fte_flag)
);

// File: tb/fifo_burst_dma_test.sv
`timescale 1ns/1ps
module fifo_burst_dma_test;

  localparam logic [31:0] C_EN = 32'h1, C_END = 32'h2, C_STOP = 32'h4, C_IE = 32'h20;
  localparam logic [31:0] C_NUL = 32'h1000, C_NULEN = 32'h1_0000, C_FORCE = 32'h100_0000;

  // vector: {dir[50], size code[49:48], bytes[47:32], memory base[31:0]}
  localparam int NV = 6;
  localparam logic [50:0] VEC [NV] = '{
    {1'b1, 2'b10, 16'd64, 32'h1000_0000},
    {1'b0, 2'b10, 16'd70, 32'h2000_0040},
    {1'b1, 2'b10, 16'd1,  32'h0000_0100},
    {1'b0, 2'b01, 16'd40, 32'h3000_0000},
    {1'b1, 2'b00, 16'd20, 32'h4000_0000},
    {1'b0, 2'b11, 16'd33, 32'h5000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        glob_en = 1'b1, addr_err = 1'b0, dev_to_mem = 1'b0;
  logic        stop_req = 1'b0, null_pkt = 1'b0;
  logic        mem_req, mem_we, mem_ack = 1'b0, irq;
  logic [31:0] mem_addr, mem_strb;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  fifo_burst_dma uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glob_en(glob_en),
    .addr_err(addr_err), .dev_to_mem(dev_to_mem), .stop_req(stop_req),
    .null_pkt(null_pkt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_strb(mem_strb), .mem_ack(mem_ack), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_strb(input int step, input bit last, input logic [31:0] m);
    logic [31:0] s;
    s = '0;
    for (int b = 0; b < step; b++) if (!last || m[31-b]) s[b] = 1'b1;
    return s;
  endfunction

  // acknowledge model and unit monitor
  int ack_delay = 0, wcnt = 0, seen = 0;
  bit mon_chk = 1'b0;
  logic [31:0] exp_base, exp_mask;
  int exp_step = 32, exp_units = 1;
  bit exp_we = 1'b0;

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wcnt >= ack_delay) begin
        mem_ack = 1'b1;
        wcnt = 0;
        if (mon_chk) begin
          check(mem_addr == exp_base + 32'(seen * exp_step), "R4 unit address", mem_addr,
                exp_base + 32'(seen * exp_step));
          check(mem_we == exp_we, "R4 direction", 32'(mem_we), 32'(exp_we));
          check(mem_strb == exp_strb(exp_step, seen == exp_units - 1, exp_mask),
                "R6 strobes", mem_strb, exp_strb(exp_step, seen == exp_units - 1, exp_mask));
          check(seen < exp_units, "R3 extra unit", 32'(seen), 32'(exp_units));
        end
        seen++;
      end else wcnt++;
    end
  end

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input int limit);
    for (int i = 0; i < limit && !irq; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  logic [31:0] rd;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a <= 24; a += 4) begin
      reg_rd(5'(a), rd);
      check(rd == 0, "R1 register after reset", rd, 0);
    end
    check(!mem_req && !irq, "R1 outputs after reset", {30'b0, mem_req, irq}, 0);

    // R2 register map
    reg_wr(5'h00, 32'h1234_5678); reg_rd(5'h00, rd);
    check(rd == 32'h1234_5678, "R2 source readback", rd, 32'h1234_5678);
    reg_wr(5'h04, 32'h9abc_def0); reg_rd(5'h04, rd);
    check(rd == 32'h9abc_def0, "R2 destination readback", rd, 32'h9abc_def0);
    reg_wr(5'h08, 32'hffff_ffff); reg_rd(5'h08, rd);
    check(rd == 32'h00ff_ffff, "R2 count width", rd, 32'h00ff_ffff);
    reg_wr(5'h18, 32'hf0f0_0000); reg_rd(5'h18, rd);
    check(rd == 32'hf0f0_0000, "R2 mask readback", rd, 32'hf0f0_0000);
    reg_wr(5'h14, C_IE | 32'h40); reg_rd(5'h14, rd);
    check(rd == (C_IE | 32'h40), "R2 control readback", rd, C_IE | 32'h40);
    check(!mem_req, "R3 no request while disabled", 32'(mem_req), 0);

    // R9 writing 1 to clear flags has no effect
    reg_wr(5'h14, C_END | C_STOP | C_NUL);
    reg_rd(5'h14, rd);
    check(rd == 0, "R9 write one to clear flag", rd, 0);

    // vector table: main transfers
    for (int v = 0; v < NV; v++) begin
      logic [50:0] e;
      int step, units, rem;
      logic [31:0] base, other, m;
      e = VEC[v];
      step = (e[49:48] == 2'b00) ? 8 : (e[49:48] == 2'b01) ? 16 : 32;
      units = (int'(e[47:32]) + step - 1) / step;
      rem = int'(e[47:32]) % step;
      if (rem == 0) rem = step;
      m = 32'hffff_ffff << (32 - rem);
      base = e[31:0];
      other = 32'hdead_0000 + 32'(v);
      dev_to_mem = e[50];
      ack_delay = v % 3;
      reg_wr(5'h00, e[50] ? other : base);
      reg_wr(5'h04, e[50] ? base : other);
      reg_wr(5'h08, 32'(units));
      reg_wr(5'h18, m);
      exp_base = base; exp_mask = m; exp_step = step; exp_units = units; exp_we = e[50];
      seen = 0; mon_chk = 1'b1;
      reg_wr(5'h14, C_EN | C_IE | {24'b0, e[49:48], 6'b0});
      wait_irq(400);
      idle(10);
      check(seen == units, "R3 units per transfer", 32'(seen), 32'(units));
      check(irq == 1'b1, "R8 irq on end", 32'(irq), 1);
      reg_rd(5'h14, rd);
      check(rd[1] == 1'b1, "R7 end flag", rd, rd | C_END);
      reg_rd(e[50] ? 5'h04 : 5'h00, rd);
      check(rd == base + 32'(units * step), "R4 final address", rd, base + 32'(units * step));
      reg_rd(e[50] ? 5'h00 : 5'h04, rd);
      check(rd == other, "R4 other address unchanged", rd, other);
      reg_rd(5'h08, rd);
      check(rd == 0, "R4 count exhausted", rd, 0);
      check(!mem_req, "R7 no request after end", 32'(mem_req), 0);
      mon_chk = 1'b0;
      reg_wr(5'h14, 32'h0);
      check(irq == 1'b0, "R9 acknowledge clears irq", 32'(irq), 0);
    end

    // R8 end without interrupt enable
    dev_to_mem = 1'b1; ack_delay = 0; seen = 0;
    reg_wr(5'h08, 32'd2);
    reg_wr(5'h14, C_EN | 32'h80);
    idle(30);
    reg_rd(5'h14, rd);
    check(rd[1] == 1'b1 && irq == 1'b0, "R8 no irq without enable", {rd[31:1], irq}, C_END);
    reg_wr(5'h14, 32'h0);

    // R13 run gate
    glob_en = 1'b0; seen = 0;
    reg_wr(5'h08, 32'd2);
    reg_wr(5'h14, C_EN | C_IE | 32'h80);
    begin
      bit any;
      any = 1'b0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); any |= mem_req; end
      check(!any, "R13 held by global disable", 32'(any), 0);
      glob_en = 1'b1; addr_err = 1'b1; any = 1'b0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); any |= mem_req; end
      check(!any, "R13 held by address error", 32'(any), 0);
    end
    addr_err = 1'b0;
    wait_irq(100);
    check(seen == 2 && irq, "R13 resumes after enable", 32'(seen), 2);
    reg_wr(5'h14, 32'h0);

    // R10 stop request
    ack_delay = 3; seen = 0;
    reg_wr(5'h08, 32'd4);
    reg_wr(5'h14, C_EN | C_IE | 32'h80);
    for (int i = 0; i < 100 && seen < 1; i++) @(negedge clk);
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    idle(20);
    reg_rd(5'h14, rd);
    check(rd[2] == 1'b1 && rd[1] == 1'b0, "R10 stop flag set", rd, C_EN | C_STOP);
    check(irq && !mem_req && seen < 4, "R10 halted with irq", 32'(seen), 32'(1));
    reg_rd(5'h08, rd);
    check(rd == 32'(4 - seen), "R10 remaining count", rd, 32'(4 - seen));
    reg_wr(5'h14, 32'h0);

    // R11 null packet, then R12 forced end (run held off so the channel stays busy)
    glob_en = 1'b0;
    reg_wr(5'h08, 32'd5);
    reg_wr(5'h14, C_EN | C_IE | 32'h80);
    null_pkt = 1'b1; @(negedge clk); null_pkt = 1'b0;
    reg_rd(5'h14, rd);
    check(rd[12] == 1'b0 && !irq, "R11 null ignored when detect off", rd, C_EN | C_IE | 32'h80);
    reg_wr(5'h14, C_EN | C_IE | C_NULEN | 32'h80);
    null_pkt = 1'b1; @(negedge clk); null_pkt = 1'b0;
    reg_rd(5'h14, rd);
    check(rd[12] == 1'b1 && irq, "R11 null flag and irq", rd, C_EN | C_IE | C_NULEN | C_NUL | 32'h80);
    reg_wr(5'h14, C_EN | C_IE | C_NULEN | C_FORCE | 32'h80);
    idle(3);
    reg_rd(5'h14, rd);
    check(rd == (C_EN | C_END | C_IE | C_NULEN | 32'h80), "R12 forced end", rd,
          C_EN | C_END | C_IE | C_NULEN | 32'h80);
    reg_rd(5'h08, rd);
    check(rd == 32'd5, "R12 count left as it was", rd, 32'd5);
    reg_wr(5'h14, 32'h0);
    glob_en = 1'b1;

    idle(5);
    finish_run();
  end

endmodule